// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block sits between a small 8-bit core and its data storage. It takes one access per cycle and sorts it into a region. A direct access names a bank through a 5-bit bank number and a location through a 7-bit offset. An indirect access gives a 16-bit pointer instead. The regions are core registers, peripheral registers, banked general RAM, a small RAM shared by all banks, unimplemented space and program memory. The block holds the two RAMs itself. It passes register writes out on a separate port and takes register read data from an external register file. Program-memory reads go through an address/word pair, and the block returns the low byte of the fetched word.

Each result is registered. Region code, RAM index and read data appear in the cycle after the access. A program-memory read works differently: the block raises a one-cycle stall and returns its data one cycle later than a normal read. Only the first `GPR_BANKS` banks have general RAM. The same offsets in higher banks read as zero.

Top module: `bank_mem_decode`

## Requirements
- R1: After synchronous reset, `rd_valid`, `stall` and `reg_we` are 0, `region` is 4 (unimplemented) and `rdata` is 0.
- R2: For a direct access, the offset alone selects the region, reported in `region` the cycle after the access. Offsets 0x00–0x0B give code 0 (core). Offsets 0x0C–0x1F give code 1 (peripheral). Offsets 0x20–0x6F give code 2 (general RAM). Offsets 0x70–0x7F give code 3 (shared RAM). Core and shared results do not depend on the bank number.
- R3: A general-RAM offset in a bank below `GPR_BANKS` (default 4) gives `ram_index` = bank*80 + (offset−0x20). In any higher bank it gives code 4. `ram_index` is 0 for every region other than codes 2 and 3.
- R4: Shared RAM uses `ram_index` = offset−0x70, and a byte written through any bank reads back through every bank.
- R5: A read of general or shared RAM returns the last byte written to that physical location on `rdata`, with `rd_valid` high for one cycle, the cycle after the access.
- R6: A read of unimplemented space returns 0x00 with `rd_valid`. A write there causes no `reg_we` and changes no RAM contents.
- R7: A core or peripheral write pulses `reg_we` for one cycle, the cycle after the access, with `reg_waddr` = offset and `reg_wdata` = the written byte. Nothing is stored in RAM. A read of these regions drives `reg_raddr` = offset during the access and returns the `reg_rdata` seen then.
- R8: An indirect access with pointer bit 15 clear and bits 14:12 zero uses bank = pointer[11:7] and offset = pointer[6:0], under the same rules as a direct access. Bits 14:12 non-zero give code 4.
- R9: An indirect read with pointer bit 15 set gives code 5. The cycle after the access, `stall` is high for exactly one cycle, `rd_valid` is low and `pm_addr` = pointer[14:0]. In the next cycle `rd_valid` is high and `rdata` = bits 7:0 of `pm_word`.
- R10: An indirect write with pointer bit 15 set gives code 5 but raises no `stall`, no `reg_we` and no `rd_valid`.
- R11: An access presented while `stall` is high is dropped. It causes no register write and no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_indirect | input | 1 | 1 = use `ptr`, 0 = use `bank_sel`/`offset` |
| bank_sel | input | 5 | Bank number for direct access |
| offset | input | 7 | In-bank offset for direct access |
| ptr | input | 16 | Pointer for indirect access |
| wdata | input | 8 | Write data |
| reg_rdata | input | 8 | Register file read data for `reg_raddr` |
| pm_word | input | 14 | Program-memory word at `pm_addr` |
| region | output | 3 | Region code of the last accepted access |
| ram_index | output | IDX_W (9) | Physical RAM index of the last accepted access |
| rdata | output | 8 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data strobe |
| stall | output | 1 | Extra cycle for a program-memory read |
| reg_raddr | output | 7 | Register read offset for the current access |
| reg_we | output | 1 | Register write strobe |
| reg_waddr | output | 7 | Register write offset |
| reg_wdata | output | 8 | Register write data |
| pm_addr | output | 15 | Program-memory word address |

## Verification
A wrong bank or offset split shows up in `region` and `ram_index` one cycle after the access. A wrong GPR index stays hidden until a later read returns a byte from another location. The bench closes that gap by keeping a model of both RAMs and reading back over many random accesses. A broken stall sequence shows in the two cycles after a program-memory read, as a missing or doubled `stall` or a misplaced `rd_valid`. A leak of dropped accesses appears only in later reads of the location they targeted.

// File: rtl/bmd_pkg.sv
`timescale 1ns/1ps
package bmd_pkg;
  localparam int BANK_W     = 5;
  localparam int OFF_W      = 7;
  localparam int PTR_W      = 16;
  localparam int PM_ADDR_W  = 15;
  localparam int PM_WORD_W  = 14;
  localparam int DATA_W     = 8;
  localparam int GPR_PER_BANK = 80;
  localparam int COM_DEPTH  = 16;
  localparam int COM_AW     = $clog2(COM_DEPTH);

  localparam logic [OFF_W-1:0] SFR_BASE = 7'h0C;
  localparam logic [OFF_W-1:0] GPR_BASE = 7'h20;
  localparam logic [OFF_W-1:0] COM_BASE = 7'h70;

  typedef enum logic [2:0] {
    RG_CORE   = 3'd0,
    RG_SFR    = 3'd1,
    RG_GPR    = 3'd2,
    RG_COMMON = 3'd3,
    RG_UNIMPL = 3'd4,
    RG_PROG   = 3'd5
  } region_e;
endpackage

// File: rtl/bmd_classify.sv
`timescale 1ns/1ps
module bmd_classify
  import bmd_pkg::*;
#(
  parameter int GPR_BANKS = 4,
  parameter int IDX_W     = 9
) (
  input  logic                 indirect,
  input  logic [BANK_W-1:0]    bank_sel,
  input  logic [OFF_W-1:0]     offset,
  input  logic [PTR_W-1:0]     ptr,
  output region_e              region,
  output logic [IDX_W-1:0]     ram_idx,
  output logic [OFF_W-1:0]     eff_off
);
  logic [BANK_W-1:0] eff_bank;
  logic              ptr_prog;
  logic              ptr_hole;

  // pointer layout: bit 15 selects program memory, bits 14:12 must be zero
  assign ptr_prog = indirect && ptr[PTR_W-1];
  assign ptr_hole = indirect && !ptr[PTR_W-1] && (ptr[PTR_W-2:BANK_W+OFF_W] != '0);

  always_comb begin
    if (indirect) begin
      eff_bank = ptr[BANK_W+OFF_W-1:OFF_W];
      eff_off  = ptr[OFF_W-1:0];
    end else begin
      eff_bank = bank_sel;
      eff_off  = offset;
    end
  end

  always_comb begin
    region  = RG_UNIMPL;
    ram_idx = '0;
    if (ptr_prog) begin
      region = RG_PROG;
    end else if (ptr_hole) begin
      region = RG_UNIMPL;
    end else if (eff_off < SFR_BASE) begin
      region = RG_CORE;
    end else if (eff_off < GPR_BASE) begin
      region = RG_SFR;
    end else if (eff_off < COM_BASE) begin
      if (int'(eff_bank) < GPR_BANKS) begin
        region  = RG_GPR;
        ram_idx = IDX_W'(eff_bank) * IDX_W'(GPR_PER_BANK)
                + IDX_W'(eff_off - GPR_BASE);
      end
    end else begin
      region  = RG_COMMON;
      ram_idx = IDX_W'(eff_off - COM_BASE);
    end
  end
endmodule

// File: rtl/bmd_sram.sv
`timescale 1ns/1ps
module bmd_sram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/bank_mem_decode.sv
`timescale 1ns/1ps
module bank_mem_decode
  import bmd_pkg::*;
#(
  parameter int GPR_BANKS = 4,
  localparam int GPR_DEPTH = GPR_BANKS * GPR_PER_BANK,
  localparam int IDX_W     = $clog2(GPR_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic                  acc_indirect,
  input  logic [BANK_W-1:0]     bank_sel,
  input  logic [OFF_W-1:0]      offset,
  input  logic [PTR_W-1:0]      ptr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W-1:0]     reg_rdata,
  input  logic [PM_WORD_W-1:0]  pm_word,
  output logic [2:0]            region,
  output logic [IDX_W-1:0]      ram_index,
  output logic [DATA_W-1:0]     rdata,
  output logic                  rd_valid,
  output logic                  stall,
  output logic [OFF_W-1:0]      reg_raddr,
  output logic                  reg_we,
  output logic [OFF_W-1:0]      reg_waddr,
  output logic [DATA_W-1:0]     reg_wdata,
  output logic [PM_ADDR_W-1:0]  pm_addr
);
  region_e          dec_region;
  logic [IDX_W-1:0] dec_idx;
  logic [OFF_W-1:0] dec_off;

  bmd_classify #(.GPR_BANKS(GPR_BANKS), .IDX_W(IDX_W)) u_class (
    .indirect (acc_indirect),
    .bank_sel (bank_sel),
    .offset   (offset),
    .ptr      (ptr),
    .region   (dec_region),
    .ram_idx  (dec_idx),
    .eff_off  (dec_off)
  );

  logic take, is_reg;
  assign take   = acc_valid && !stall_q;
  assign is_reg = (dec_region == RG_CORE) || (dec_region == RG_SFR);

  logic gpr_we, gpr_re, com_we, com_re;
  assign gpr_we = take &&  acc_write && (dec_region == RG_GPR);
  assign gpr_re = take && !acc_write && (dec_region == RG_GPR);
  assign com_we = take &&  acc_write && (dec_region == RG_COMMON);
  assign com_re = take && !acc_write && (dec_region == RG_COMMON);

  logic [DATA_W-1:0] gpr_dout, com_dout;

  bmd_sram #(.W(DATA_W), .DEPTH(GPR_DEPTH), .AW(IDX_W)) u_gpr (
    .clk(clk), .we(gpr_we), .re(gpr_re), .addr(dec_idx),
    .wdata(wdata), .rdata(gpr_dout)
  );

  bmd_sram #(.W(DATA_W), .DEPTH(COM_DEPTH), .AW(COM_AW)) u_com (
    .clk(clk), .we(com_we), .re(com_re), .addr(dec_idx[COM_AW-1:0]),
    .wdata(wdata), .rdata(com_dout)
  );

  region_e           region_q;
  logic [IDX_W-1:0]  idx_q;
  logic              rd_valid_q, stall_q, reg_we_q;
  logic [OFF_W-1:0]  reg_waddr_q;
  logic [DATA_W-1:0] reg_wdata_q, regrd_q, pm_lo_q;
  logic [PM_ADDR_W-1:0] pm_addr_q;
  logic              unused_pm_hi;

  assign unused_pm_hi = ^pm_word[PM_WORD_W-1:DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      region_q    <= RG_UNIMPL;
      idx_q       <= '0;
      rd_valid_q  <= 1'b0;
      stall_q     <= 1'b0;
      reg_we_q    <= 1'b0;
      reg_waddr_q <= '0;
      reg_wdata_q <= '0;
      regrd_q     <= '0;
      pm_addr_q   <= '0;
      pm_lo_q     <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      reg_we_q   <= 1'b0;
      stall_q    <= 1'b0;
      if (stall_q) begin
        pm_lo_q    <= pm_word[DATA_W-1:0];
        rd_valid_q <= 1'b1;
      end else if (acc_valid) begin
        region_q <= dec_region;
        idx_q    <= dec_idx;
        if (acc_write) begin
          if (is_reg) begin
            reg_we_q    <= 1'b1;
            reg_waddr_q <= dec_off;
            reg_wdata_q <= wdata;
          end
        end else if (dec_region == RG_PROG) begin
          stall_q   <= 1'b1;
          pm_addr_q <= ptr[PM_ADDR_W-1:0];
        end else begin
          rd_valid_q <= 1'b1;
          if (is_reg) regrd_q <= reg_rdata;
        end
      end
    end
  end

  always_comb begin
    unique case (region_q)
      RG_GPR:          rdata = gpr_dout;
      RG_COMMON:       rdata = com_dout;
      RG_CORE, RG_SFR: rdata = regrd_q;
      RG_PROG:         rdata = pm_lo_q;
      default:         rdata = '0;
    endcase
  end

  assign region    = region_q;
  assign ram_index = idx_q;
  assign rd_valid  = rd_valid_q;
  assign stall     = stall_q;
  assign reg_raddr = dec_off;
  assign reg_we    = reg_we_q;
  assign reg_waddr = reg_waddr_q;
  assign reg_wdata = reg_wdata_q;
  assign pm_addr   = pm_addr_q;

  // R9
  stall_single_chk: assert property (@(posedge clk) disable iff (rst)
    stall_q |=> !stall_q);

  // R9
  prog_read_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !acc_write && dec_region == RG_PROG) |=> (stall_q && !rd_valid_q));

  // R9
  stall_to_data_chk: assert property (@(posedge clk) disable iff (rst)
    stall_q |=> (rd_valid_q && region_q == RG_PROG));

  // R7
  reg_we_region_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we_q |-> (region_q == RG_CORE || region_q == RG_SFR));

  // R3
  gpr_index_range_chk: assert property (@(posedge clk) disable iff (rst)
    (region_q == RG_GPR) |-> (int'(idx_q) < GPR_DEPTH));

  // R11
  drop_during_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_q && acc_valid) |=> (!reg_we_q && region_q == RG_PROG));

  // R10
  prog_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (take && acc_write && dec_region == RG_PROG) |=> (!stall_q && !rd_valid_q && !reg_we_q));
endmodule

// File: tb/bank_mem_decode_test.sv
`timescale 1ns/1ps
module bank_mem_decode_test;
  localparam int GB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 0, acc_write = 0, acc_indirect = 0;
  logic [4:0]  bank_sel = 0;
  logic [6:0]  offset = 0;
  logic [15:0] ptr = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  reg_rdata;
  logic [13:0] pm_word;
  logic [2:0]  region;
  logic [8:0]  ram_index;
  logic [7:0]  rdata;
  logic        rd_valid, stall, reg_we;
  logic [6:0]  reg_raddr, reg_waddr;
  logic [7:0]  reg_wdata;
  logic [14:0] pm_addr;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] regf(input logic [6:0] a);
    return {a, 1'b1} ^ 8'hA5;
  endfunction
  function automatic logic [13:0] pmf(input logic [14:0] a);
    return a[13:0] ^ 14'h15E3;
  endfunction

  assign reg_rdata = regf(reg_raddr);
  assign pm_word   = pmf(pm_addr);

  bank_mem_decode #(.GPR_BANKS(GB)) uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_indirect(acc_indirect), .bank_sel(bank_sel), .offset(offset),
    .ptr(ptr), .wdata(wdata), .reg_rdata(reg_rdata), .pm_word(pm_word),
    .region(region), .ram_index(ram_index), .rdata(rdata),
    .rd_valid(rd_valid), .stall(stall), .reg_raddr(reg_raddr),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .pm_addr(pm_addr)
  );

  int checks = 0, fails = 0;
  logic [7:0] gpr_m [GB*80];
  logic [7:0] com_m [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void exp_map(input bit ind, input logic [4:0] b,
      input logic [6:0] o, input logic [15:0] p,
      output int rg, output int ix, output logic [6:0] eo);
    logic [4:0] eb;
    eb = b; eo = o; ix = 0; rg = 4;
    if (ind) begin
      eb = p[11:7]; eo = p[6:0];
      if (p[15]) begin rg = 5; return; end
      if (p[14:12] != 0) begin rg = 4; return; end
    end
    if (eo < 7'h0C) rg = 0;
    else if (eo < 7'h20) rg = 1;
    else if (eo < 7'h70) begin
      if (int'(eb) < GB) begin rg = 2; ix = int'(eb) * 80 + int'(eo) - 32; end
      else rg = 4;
    end else begin rg = 3; ix = int'(eo) - 112; end
  endfunction

  task automatic access(input bit wr, input bit ind, input logic [4:0] b,
      input logic [6:0] o, input logic [15:0] p, input logic [7:0] wd);
    int rg, ix;
    logic [6:0] eo;
    logic [7:0] ev;
    string rq;
    exp_map(ind, b, o, p, rg, ix, eo);
    rq = ind ? "R8" : (rg == 3 ? "R4" : (rg == 2 || rg == 4) ? "R3" : "R2");
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_indirect = ind;
    bank_sel = b; offset = o; ptr = p; wdata = wd;
    @(negedge clk);
    acc_valid = 0;
    chk(int'(region) == rg, rq, "region", int'(region), rg);
    chk(int'(ram_index) == ix, rq, "ram_index", int'(ram_index), ix);
    if (wr) begin
      chk(rd_valid == 0 && stall == 0, (rg == 5) ? "R10" : "R5", "no read/stall on write",
          {rd_valid, stall}, 0);
      if (rg <= 1) begin
        chk(reg_we == 1 && reg_waddr == eo && reg_wdata == wd, "R7", "reg write port",
            {reg_we, reg_waddr, reg_wdata}, {1'b1, eo, wd});
      end else begin
        chk(reg_we == 0, (rg == 5) ? "R10" : "R6", "reg_we quiet", reg_we, 0);
      end
      if (rg == 2) gpr_m[ix] = wd;
      if (rg == 3) com_m[ix] = wd;
    end else if (rg == 5) begin
      chk(stall == 1 && rd_valid == 0, "R9", "stall cycle", {stall, rd_valid}, 2);
      chk(pm_addr == p[14:0], "R9", "pm_addr", pm_addr, p[14:0]);
      @(negedge clk);
      ev = pmf(p[14:0])[7:0];
      chk(stall == 0 && rd_valid == 1, "R9", "data cycle", {stall, rd_valid}, 1);
      chk(rdata == ev, "R9", "pm rdata", rdata, ev);
    end else begin
      case (rg)
        0, 1: ev = regf(eo);
        2: ev = gpr_m[ix];
        3: ev = com_m[ix];
        default: ev = 8'h00;
      endcase
      chk(rd_valid == 1 && stall == 0, "R5", "rd_valid", {rd_valid, stall}, 2);
      chk(rdata == ev, (rg <= 1) ? "R7" : (rg == 4) ? "R6" : "R5", "rdata", rdata, ev);
    end
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    s = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_valid == 0 && stall == 0 && reg_we == 0, "R1", "strobes", {rd_valid, stall, reg_we}, 0);
    chk(region == 3'd4 && rdata == 8'h00, "R1", "region/rdata", {region, rdata}, {3'd4, 8'h00});
    rst = 0;

    // fill all RAM through direct writes (R5)
    for (int b = 0; b < GB; b++)
      for (int o = 32; o < 112; o++)
        access(1, 0, 5'(b), 7'(o), 16'h0, 8'($urandom));
    for (int o = 112; o < 128; o++) access(1, 0, 5'(o), 7'(o), 16'h0, 8'($urandom));

    // directed corners (R2, R3, R4, R6, R8)
    access(0, 0, 5'd0,  7'h0B, 16'h0, 8'h0);
    access(0, 0, 5'd31, 7'h0C, 16'h0, 8'h0);
    access(0, 0, 5'd3,  7'h6F, 16'h0, 8'h0);
    access(0, 0, 5'd4,  7'h20, 16'h0, 8'h0);
    access(1, 0, 5'd9,  7'h40, 16'h0, 8'h77);
    access(1, 0, 5'd17, 7'h75, 16'h0, 8'hC3);
    access(0, 0, 5'd2,  7'h75, 16'h0, 8'h0);
    access(0, 1, 5'd0,  7'h0,  16'h0FFF, 8'h0);
    access(0, 1, 5'd0,  7'h0,  16'h1020, 8'h0);
    access(1, 1, 5'd0,  7'h0,  16'h0185, 8'h3C);
    access(0, 1, 5'd0,  7'h0,  16'h8000, 8'h0);
    access(0, 1, 5'd0,  7'h0,  16'hFFFF, 8'h0);
    access(1, 1, 5'd0,  7'h0,  16'h8123, 8'h99);

    // R11: access during stall is dropped
    begin
      logic [7:0] old;
      old = gpr_m[0];
      @(negedge clk);
      acc_valid = 1; acc_write = 0; acc_indirect = 1; ptr = 16'h8ABC;
      @(negedge clk);
      chk(stall == 1, "R11", "stall present", stall, 1);
      acc_write = 1; acc_indirect = 0; bank_sel = 0; offset = 7'h20; wdata = ~old;
      @(negedge clk);
      acc_valid = 0;
      chk(reg_we == 0 && rd_valid == 1, "R11", "dropped write", {reg_we, rd_valid}, 1);
      access(0, 0, 5'd0, 7'h20, 16'h0, 8'h0);
      chk(gpr_m[0] == old, "R11", "model intact", gpr_m[0], old);
    end

    // constrained random mix
    for (int i = 0; i < 1500; i++) begin
      int unsigned k;
      logic [15:0] p;
      k = $urandom % 8;
      p = 16'($urandom);
      if (k == 5) p[15] = 1'b1;
      else if (k < 4) p[15:12] = 4'h0;
      access(1'($urandom % 2), (k >= 3), 5'($urandom % 8), 7'($urandom), p, 8'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule